// File: doc/BRIEF.md
# SDRAM Auto-Refresh Sequencer

This block runs the refresh part of an SDR SDRAM controller. A refresh requester raises a level request. The block accepts it only while it is idle. If the controller reports that some bank is still open, the block first places a precharge-all command on the bus and waits out the row-precharge time. It then issues a fixed number of auto-refresh commands, spaced by the row-cycle time, and fills every gap with no-operation cycles.

While a sequence is in progress the block withdraws its grant to the host command path. The host therefore cannot place an activate, mode-register or any other command inside a row-cycle window. The grant returns, together with a one-cycle acknowledge, on the first cycle after the row-cycle time that follows the last refresh. The refresh row and bank come from the device's own counter, so the block drives the bank address to zero on refresh cycles to keep the bus deterministic.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset the block is idle. The command bus shows deselect ({cs_n,ras_n,cas_n,we_n} = 4'b1111), host_grant is 1 and refresh_ack is 0.
- R2: When refresh_req is high in the idle state and banks_idle is 0, the next cycle carries a precharge-all (4'b0010 with cmd_allbank = 1).
- R3: The first refresh (4'b0001) follows the precharge-all by exactly TRP_CYC cycles.
- R4: When refresh_req is accepted with banks_idle = 1, no precharge is issued and the first refresh appears on the cycle after acceptance.
- R5: On every refresh cycle cmd_ba is all zeros and cmd_allbank is 0.
- R6: Consecutive refreshes of one sequence are exactly TRC_CYC cycles apart. Every cycle inside a row-cycle window carries only no-operation (4'b0111) or deselect.
- R7: Each accepted request produces exactly REF_COUNT refresh commands.
- R8: refresh_ack is high for exactly one cycle, TRC_CYC cycles after the final refresh. host_grant is high in that same cycle.
- R9: host_grant is 0 from the cycle after acceptance until the acknowledge cycle.
- R10: refresh_req and banks_idle have no effect once a sequence has started. A low refresh_req in the idle state leaves the bus at deselect with host_grant held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| refresh_req | input | 1 | Level refresh request, dropped by the requester on acknowledge |
| banks_idle | input | 1 | 1 when every bank is already precharged |
| refresh_ack | output | 1 | One-cycle pulse when the sequence is complete |
| host_grant | output | 1 | 1 when the host may drive commands |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BA_W | Bank address, zero during refresh |
| cmd_allbank | output | 1 | All-bank select bit, set on precharge-all |

## Verification
The hardest case to reach is a change on refresh_req or banks_idle while a sequence is running. A requester that behaves well holds its request steady and waits for the acknowledge, so that change never comes from it. The stimulus toggles both inputs on every cycle of some sequences while keeping the command-by-command expectations fixed. It also sweeps both precharge paths and several idle gaps between requests. Any late sampling or restart would then move a refresh off its computed cycle.

// File: rtl/sdram_refresh_pkg.sv
`timescale 1ns/1ps
package sdram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRECHARGE_ALL,
    ST_WAIT_TRP,
    ST_REFRESH,
    ST_WAIT_TRC,
    ST_DONE
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] sdr_cmd_t;

  localparam sdr_cmd_t CMD_DESL = 4'b1111;
  localparam sdr_cmd_t CMD_NOP  = 4'b0111;
  localparam sdr_cmd_t CMD_PRE  = 4'b0010;
  localparam sdr_cmd_t CMD_REF  = 4'b0001;

endpackage

// File: rtl/refresh_rst_sync.sv
`timescale 1ns/1ps
module refresh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_in) begin
          if (!rst_n_in) sync_q[g] <= 1'b0;
          else           sync_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n_in) begin
          if (!rst_n_in) sync_q[g] <= 1'b0;
          else           sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/refresh_wait_timer.sv
`timescale 1ns/1ps
module refresh_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/refresh_burst_counter.sv
`timescale 1ns/1ps
module refresh_burst_counter #(
  parameter int REF_COUNT = 2,
  localparam int CW = $clog2(REF_COUNT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic incr,
  output logic all_issued
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear || incr;
    cnt_d  = clear ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign all_issued = (cnt_q == CW'(REF_COUNT));

endmodule

// File: rtl/refresh_seq_fsm.sv
`timescale 1ns/1ps
module refresh_seq_fsm
  import sdram_refresh_pkg::*;
#(
  parameter int TRP_CYC = 3,
  parameter int TRC_CYC = 7,
  parameter int TW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          refresh_req,
  input  logic          banks_idle,
  input  logic          tmr_expired,
  input  logic          refs_all_issued,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          cnt_clear,
  output logic          cnt_incr,
  output sdr_cmd_t      cmd,
  output logic          allbank,
  output logic          ack,
  output logic          grant
);

  seq_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    cnt_clear = 1'b0;
    cnt_incr  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        cnt_clear = 1'b1;
        if (refresh_req) st_d = banks_idle ? ST_REFRESH : ST_PRECHARGE_ALL;
      end
      ST_PRECHARGE_ALL: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(TRP_CYC - 2);
        st_d     = ST_WAIT_TRP;
      end
      ST_WAIT_TRP: begin
        if (tmr_expired) st_d = ST_REFRESH;
      end
      ST_REFRESH: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(TRC_CYC - 2);
        cnt_incr = 1'b1;
        st_d     = ST_WAIT_TRC;
      end
      ST_WAIT_TRC: begin
        if (tmr_expired) st_d = refs_all_issued ? ST_DONE : ST_REFRESH;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    cmd     = CMD_DESL;
    allbank = 1'b0;
    case (st_q)
      ST_PRECHARGE_ALL: begin cmd = CMD_PRE; allbank = 1'b1; end
      ST_WAIT_TRP:      cmd = CMD_NOP;
      ST_REFRESH:       cmd = CMD_REF;
      ST_WAIT_TRC:      cmd = CMD_NOP;
      default:          cmd = CMD_DESL;
    endcase
  end

  assign ack   = (st_q == ST_DONE);
  assign grant = (st_q == ST_IDLE) || (st_q == ST_DONE);

endmodule

// File: rtl/sdram_refresh_seq.sv
`timescale 1ns/1ps
module sdram_refresh_seq
  import sdram_refresh_pkg::*;
#(
  parameter int TRP_CYC    = 3,
  parameter int TRC_CYC    = 7,
  parameter int REF_COUNT  = 2,
  parameter int BA_W       = 2,
  parameter int SYNC_STAGE = 2,
  localparam int TMAX = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC,
  localparam int TW   = $clog2(TMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            refresh_req,
  input  logic            banks_idle,
  output logic            refresh_ack,
  output logic            host_grant,
  output logic            cmd_cs_n,
  output logic            cmd_ras_n,
  output logic            cmd_cas_n,
  output logic            cmd_we_n,
  output logic [BA_W-1:0] cmd_ba,
  output logic            cmd_allbank
);

  logic          rst_n_int;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          cnt_clear, cnt_incr, refs_all_issued;
  sdr_cmd_t      cmd;

  refresh_rst_sync #(.STAGES(SYNC_STAGE)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  refresh_wait_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  refresh_burst_counter #(.REF_COUNT(REF_COUNT)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .clear      (cnt_clear),
    .incr       (cnt_incr),
    .all_issued (refs_all_issued)
  );

  refresh_seq_fsm #(.TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC), .TW(TW)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n_int),
    .refresh_req     (refresh_req),
    .banks_idle      (banks_idle),
    .tmr_expired     (tmr_expired),
    .refs_all_issued (refs_all_issued),
    .tmr_load        (tmr_load),
    .tmr_val         (tmr_val),
    .cnt_clear       (cnt_clear),
    .cnt_incr        (cnt_incr),
    .cmd             (cmd),
    .allbank         (cmd_allbank),
    .ack             (refresh_ack),
    .grant           (host_grant)
  );

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd;
  assign cmd_ba = '0;

endmodule

// File: rtl/sdram_refresh_seq_checker.sv
`timescale 1ns/1ps
module sdram_refresh_seq_checker #(
  parameter int TRP_CYC = 3,
  parameter int TRC_CYC = 7,
  parameter int BA_W    = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            refresh_ack,
  input logic            host_grant,
  input logic            cmd_cs_n,
  input logic            cmd_ras_n,
  input logic            cmd_cas_n,
  input logic            cmd_we_n,
  input logic [BA_W-1:0] cmd_ba,
  input logic            cmd_allbank
);

  localparam int CW = $clog2(((TRC_CYC > TRP_CYC) ? TRC_CYC : TRP_CYC) + 1);

  logic [3:0]    c;
  logic          is_ref, is_pre, is_quiet;
  logic [CW-1:0] since_ref, since_pre;

  assign c        = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
  assign is_ref   = (c == 4'b0001);
  assign is_pre   = (c == 4'b0010);
  assign is_quiet = (c == 4'b0111) || c[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since_ref <= CW'(TRC_CYC);
    else if (is_ref)                  since_ref <= CW'(1);
    else if (since_ref < CW'(TRC_CYC)) since_ref <= since_ref + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since_pre <= CW'(TRP_CYC);
    else if (is_pre)                  since_pre <= CW'(1);
    else if (since_pre < CW'(TRP_CYC)) since_pre <= since_pre + 1'b1;
  end

  assert_pre_is_allbank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> cmd_allbank);

  assert_pre_to_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> since_pre >= CW'(TRP_CYC));

  assert_ref_addr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (cmd_ba == '0) && !cmd_allbank);

  assert_ref_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> since_ref >= CW'(TRC_CYC));

  assert_quiet_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_ref < CW'(TRC_CYC)) |-> is_quiet);

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ack |=> !refresh_ack);

  assert_ack_with_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ack |-> host_grant);

  assert_grant_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_ref < CW'(TRC_CYC)) |-> !host_grant);

endmodule

bind sdram_refresh_seq sdram_refresh_seq_checker #(
  .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC), .BA_W(BA_W)
) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .refresh_ack (refresh_ack),
  .host_grant  (host_grant),
  .cmd_cs_n    (cmd_cs_n),
  .cmd_ras_n   (cmd_ras_n),
  .cmd_cas_n   (cmd_cas_n),
  .cmd_we_n    (cmd_we_n),
  .cmd_ba      (cmd_ba),
  .cmd_allbank (cmd_allbank)
);

// File: tb/test_sdram_refresh_seq.sv
`timescale 1ns/1ps
module test_sdram_refresh_seq;

  localparam int TRP  = 3;
  localparam int TRC  = 5;
  localparam int REFS = 3;
  localparam int BAW  = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic refresh_req, banks_idle;
  logic refresh_ack, host_grant;
  logic cs_n, ras_n, cas_n, we_n, allbank;
  logic [BAW-1:0] ba;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  sdram_refresh_seq #(
    .TRP_CYC(TRP), .TRC_CYC(TRC), .REF_COUNT(REFS), .BA_W(BAW)
  ) i_sdram_refresh_seq (
    .clk(clk), .rst_n(rst_n),
    .refresh_req(refresh_req), .banks_idle(banks_idle),
    .refresh_ack(refresh_ack), .host_grant(host_grant),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_ba(ba), .cmd_allbank(allbank)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // kind: 0 quiet (NOP or DESL), 1 precharge-all, 2 refresh
  task automatic chk_cmd(input string req, input int kind);
    logic [3:0] c;
    logic       ok;
    c = {cs_n, ras_n, cas_n, we_n};
    vectors++;
    case (kind)
      1:       ok = (c == 4'b0010) && allbank;
      2:       ok = (c == 4'b0001) && (ba == '0) && !allbank;
      default: ok = (c == 4'b0111) || (c == 4'b1111);
    endcase
    if (!ok) begin
      errors++;
      $display("FAIL %s actual cmd=%b ba=%0d ab=%b expected kind=%0d at %0t",
               req, c, ba, allbank, kind, $time);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      // R10: low request in idle leaves bus deselected with grant held
      chk("R10 idle cmd", {4'h0, cs_n, ras_n, cas_n, we_n}, 8'h0F);
      chk("R10 idle grant/ack", {6'h0, host_grant, refresh_ack}, 8'h02);
    end
  endtask

  task automatic run_seq(input bit open, input bit wiggle);
    int base, ackc, kind;
    string tag;
    refresh_req = 1'b1;
    banks_idle  = !open;
    base = open ? 1 + TRP : 1;
    ackc = base + REFS * TRC;
    for (int k = 1; k <= ackc; k++) begin
      @(negedge clk);
      kind = 0;
      tag  = "R6 quiet window";
      if (open && k == 1) begin kind = 1; tag = "R2 precharge-all"; end
      for (int i = 0; i < REFS; i++)
        if (k == base + i * TRC) begin
          kind = 2;
          tag = (i == 0) ? (open ? "R3 first refresh after precharge" : "R4 refresh without precharge")
                         : "R7 refresh spacing R5";
        end
      chk_cmd(tag, kind);
      chk((k == ackc) ? "R8 ack and grant" : "R9 grant held low",
          {6'h0, host_grant, refresh_ack},
          (k == ackc) ? 8'h03 : 8'h00);
      if (k == ackc) refresh_req = 1'b0;
      else if (wiggle) begin
        // R10: toggling inputs during a sequence must not matter
        refresh_req = k[0];
        banks_idle  = k[1];
      end
    end
    banks_idle = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    refresh_req = 1'b0;
    banks_idle = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset cmd", {4'h0, cs_n, ras_n, cas_n, we_n}, 8'h0F);
    chk("R1 reset grant/ack", {6'h0, host_grant, refresh_ack}, 8'h02);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {5'h0, host_grant, refresh_ack, cs_n}, 8'h05);
    for (int gap = 0; gap < 3; gap++)
      for (int mode = 0; mode < 4; mode++) begin
        idle_cycles(gap + 1);
        run_seq(mode[0], mode[1]);
      end
    idle_cycles(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule